// File: doc/BRIEF.md
# Ultra DMA Operation Control and Status Registers

This block is the software-facing register set that governs the Ultra DMA engine of a parallel ATA host. It holds the bus control word that drives the chip-select, address and strobe lines of the ATA bus. It also holds a configuration word that selects the transfer class and mode, and an operation word that carries the transfer direction and the engine enable. A read-only status word exposes the engine's request, busy and error indications.

Setting the engine enable is guarded. Software must first write the operation word with the direction it wants and the enable clear. It must then read the operation word back, and only then write it again with the enable set and the same direction. An enable write that does not follow this order is discarded. Error indications from the engine are latched. They are reduced, together with the device interrupt pin and the engine activity signals, to three mutually exclusive summary outputs with a fixed priority. A stop pulse returns the engine to idle and drives every ATA bus strobe and chip select to its inactive level.

Top module: `udma_ctl_regs`

## Requirements
- R1: After reset the control word (offset 0) reads 0x63, which means bits 0, 1, 5 and 6 are high. The configuration word (offset 1), the operation word (offset 2) and the status word (offset 3) read 0, and all three summary outputs are low.
- R2: In the operation word, bit 0 is the engine enable and bit 1 is the direction (1 means data is written to the device). The `op_en` and `op_write` outputs mirror these bits, and a read at offset 2 returns them in bits 1:0.
- R3: A write to offset 2 with bit 0 set enables the engine only when the preceding operation-word accesses were a write with bit 0 clear followed by at least one read, and only when its bit 1 equals the direction stored by that first write. Otherwise the write leaves the operation word unchanged. Either way the sequence must restart. Accesses to other offsets do not disturb the sequence.
- R4: The configuration word keeps bits 9:0. Bit 0 is the host enable, bit 1 selects programmed I/O, bit 2 selects multiword DMA and bit 3 selects Ultra DMA. Bits 7:4 hold the mode number and bits 9:8 hold the write hold count. All of these appear on the `cfg_*` outputs. When bit 1 of the written value is clear, bits 9:8 are stored as written.
- R5: When bit 1 of a configuration write is set, the stored hold count ignores the written bits 9:8. It is 3 for mode 0, 2 for modes 1 and 2, and 1 for mode 3 and above.
- R6: The status word at offset 3 has the following bits. Bit 16 is the live engine request. Bit 17 is the latched engine interrupt. Bit 18 is the live engine busy. Bits 24, 25 and 26 are the latched errors for data-out incomplete, data-in incomplete and a length that is not a multiple of four words. The latched bits stay set until the operation word becomes 0 through a write or a stop. An error arriving in the same cycle as the clear is kept.
- R7: `sum_err` is high while any of status bits 17, 24, 25 or 26 is set.
- R8: While `sum_err` is low, `sum_irq` follows the device interrupt pin. The pin also reads back at bit 9 of the control word.
- R9: While `sum_err` and `sum_irq` are both low, `sum_act` is high when the engine request or the engine busy input is high. At most one summary output is high at any time.
- R10: A `dma_stop` pulse clears the operation word and forces control bits 0, 1, 5 and 6 high. It leaves the address bits 4:2 as they are and takes priority over a bus write in the same cycle.
- R11: A write to offset 0 stores bits 6:0. These drive the two chip selects, the address lines and the two strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| dma_stop | input | 1 | Stop pulse |
| dev_intrq | input | 1 | Device interrupt pin |
| eng_req | input | 1 | Engine DMA request |
| eng_busy | input | 1 | Engine not idle |
| eng_int | input | 1 | Engine fault interrupt pulse |
| eng_ndo | input | 1 | Data-out incomplete pulse |
| eng_ndi | input | 1 | Data-in incomplete pulse |
| eng_n4x | input | 1 | Length not a multiple of four words pulse |
| ata_cs0_n | output | 1 | Chip select 0, active low |
| ata_cs1_n | output | 1 | Chip select 1, active low |
| ata_da | output | 3 | Device register address |
| ata_dior_n | output | 1 | Read strobe, active low |
| ata_diow_n | output | 1 | Write strobe, active low |
| cfg_host_en | output | 1 | Host enable |
| cfg_pio | output | 1 | Programmed I/O selected |
| cfg_mdma | output | 1 | Multiword DMA selected |
| cfg_udma | output | 1 | Ultra DMA selected |
| cfg_mode | output | 4 | Mode number |
| cfg_hold | output | 2 | Write hold count |
| op_en | output | 1 | Engine enable |
| op_write | output | 1 | Direction, 1 means to the device |
| sum_err | output | 1 | Error summary |
| sum_irq | output | 1 | Interrupt summary |
| sum_act | output | 1 | Activity summary |

## Verification
The hardest state to reach is an accepted enable. It needs three operation-word accesses in order with matching direction, and random traffic seldom produces that. A miss has several forms: a skipped read, a changed direction, or a fresh enable-clear write that restarts the sequence. The directed part of the stimulus therefore builds each legal order and each broken one explicitly. The random part weights the operation-word accesses heavily and mixes in other offsets, so that accepted enables and discarded ones keep recurring alongside stop pulses and error pulses. The interplay between sticky errors and their clear is covered the same way. Errors are pulsed while the operation word is non-zero and cleared later, sometimes in the same cycle as a new error.

// File: rtl/udma_ctl_regs.sv
module udma_ctl_regs #(
  parameter int AW = 2,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          dma_stop,
  input  logic          dev_intrq,
  input  logic          eng_req,
  input  logic          eng_busy,
  input  logic          eng_int,
  input  logic          eng_ndo,
  input  logic          eng_ndi,
  input  logic          eng_n4x,
  output logic          ata_cs0_n,
  output logic          ata_cs1_n,
  output logic [2:0]    ata_da,
  output logic          ata_dior_n,
  output logic          ata_diow_n,
  output logic          cfg_host_en,
  output logic          cfg_pio,
  output logic          cfg_mdma,
  output logic          cfg_udma,
  output logic [3:0]    cfg_mode,
  output logic [1:0]    cfg_hold,
  output logic          op_en,
  output logic          op_write,
  output logic          sum_err,
  output logic          sum_irq,
  output logic          sum_act
);
  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_CFG  = AW'(1);
  localparam logic [AW-1:0] A_OP   = AW'(2);
  localparam logic [AW-1:0] A_STS  = AW'(3);
  localparam logic [6:0]    IDLE_LINES = 7'h63;

  logic [6:0] ctrl_q;
  logic [9:0] cfg_q;
  logic       en_q, rw_q;
  logic [1:0] stage_q;
  logic       ndo_q, ndi_q, n4x_q, int_q;

  logic wr_ctrl, wr_cfg, wr_op, rd_op;
  logic en_ok, op_next_zero, err_clr;
  logic [1:0] hold_calc;

  assign wr_ctrl = bus_wr && bus_addr == A_CTRL;
  assign wr_cfg  = bus_wr && bus_addr == A_CFG;
  assign wr_op   = bus_wr && bus_addr == A_OP;
  assign rd_op   = bus_rd && !bus_wr && bus_addr == A_OP;

  assign en_ok = wr_op && bus_wdata[0] && stage_q == 2'd2 && bus_wdata[1] == rw_q;
  assign op_next_zero = wr_op && !bus_wdata[0] && !bus_wdata[1];
  assign err_clr = dma_stop || op_next_zero;

  assign hold_calc = (bus_wdata[7:4] == 4'd0) ? 2'd3 :
                     (bus_wdata[7:4] <  4'd3) ? 2'd2 : 2'd1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= IDLE_LINES;
      cfg_q   <= '0;
      en_q    <= 1'b0;
      rw_q    <= 1'b0;
      stage_q <= 2'd0;
    end else begin
      if (dma_stop)
        ctrl_q <= (wr_ctrl ? bus_wdata[6:0] : ctrl_q) | IDLE_LINES;
      else if (wr_ctrl)
        ctrl_q <= bus_wdata[6:0];

      if (wr_cfg)
        cfg_q <= {bus_wdata[1] ? hold_calc : bus_wdata[9:8], bus_wdata[7:0]};

      if (dma_stop) begin
        en_q    <= 1'b0;
        rw_q    <= 1'b0;
        stage_q <= 2'd0;
      end else if (wr_op) begin
        if (!bus_wdata[0]) begin
          en_q    <= 1'b0;
          rw_q    <= bus_wdata[1];
          stage_q <= 2'd1;
        end else begin
          if (en_ok) en_q <= 1'b1;
          stage_q <= 2'd0;
        end
      end else if (rd_op && stage_q != 2'd0) begin
        stage_q <= 2'd2;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {ndo_q, ndi_q, n4x_q, int_q} <= '0;
    end else begin
      ndo_q <= (ndo_q && !err_clr) || eng_ndo;
      ndi_q <= (ndi_q && !err_clr) || eng_ndi;
      n4x_q <= (n4x_q && !err_clr) || eng_n4x;
      int_q <= (int_q && !err_clr) || eng_int;
    end
  end

  assign sum_err = ndo_q || ndi_q || n4x_q || int_q;
  assign sum_irq = !sum_err && dev_intrq;
  assign sum_act = !sum_err && !dev_intrq && (eng_busy || eng_req);

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL: begin
        bus_rdata[6:0] = ctrl_q;
        bus_rdata[9]   = dev_intrq;
      end
      A_CFG:  bus_rdata[9:0] = cfg_q;
      A_OP:   bus_rdata[1:0] = {rw_q, en_q};
      A_STS: begin
        bus_rdata[16] = eng_req;
        bus_rdata[17] = int_q;
        bus_rdata[18] = eng_busy;
        bus_rdata[24] = ndo_q;
        bus_rdata[25] = ndi_q;
        bus_rdata[26] = n4x_q;
      end
      default: bus_rdata = '0;
    endcase
  end

  assign ata_cs0_n   = ctrl_q[0];
  assign ata_cs1_n   = ctrl_q[1];
  assign ata_da      = ctrl_q[4:2];
  assign ata_dior_n  = ctrl_q[5];
  assign ata_diow_n  = ctrl_q[6];
  assign cfg_host_en = cfg_q[0];
  assign cfg_pio     = cfg_q[1];
  assign cfg_mdma    = cfg_q[2];
  assign cfg_udma    = cfg_q[3];
  assign cfg_mode    = cfg_q[7:4];
  assign cfg_hold    = cfg_q[9:8];
  assign op_en       = en_q;
  assign op_write    = rw_q;

  // R3
  enable_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(op_en) |-> $past(bus_wr && bus_addr == A_OP && bus_wdata[0] && !dma_stop));

  // R3
  enable_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(op_en) |-> $stable(op_write));

  // R10
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_stop |=> !op_en && !op_write && ata_cs0_n && ata_cs1_n && ata_dior_n && ata_diow_n);

  // R6
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sum_err && !dma_stop && !(bus_wr && bus_addr == A_OP && bus_wdata[1:0] == 2'b00)) |=> sum_err);

  // R9
  summary_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sum_err, sum_irq, sum_act}));
endmodule

// File: tb/tb_udma_ctl_regs.sv
`timescale 1ns/1ps
module tb_udma_ctl_regs;
  logic clk = 0, rst_n = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [1:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic dma_stop = 0, dev_intrq = 0, eng_req = 0, eng_busy = 0;
  logic eng_int = 0, eng_ndo = 0, eng_ndi = 0, eng_n4x = 0;
  logic ata_cs0_n, ata_cs1_n, ata_dior_n, ata_diow_n;
  logic [2:0] ata_da;
  logic cfg_host_en, cfg_pio, cfg_mdma, cfg_udma;
  logic [3:0] cfg_mode;
  logic [1:0] cfg_hold;
  logic op_en, op_write, sum_err, sum_irq, sum_act;

  int checks = 0, fails = 0;
  bit done = 0;

  // model state
  logic [6:0] m_ctrl;
  logic [9:0] m_cfg;
  logic m_en, m_rw;
  int   m_stage;
  logic m_ndo, m_ndi, m_n4x, m_int;

  always #2.5 clk = ~clk;

  udma_ctl_regs dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] hold_of(logic [3:0] m);
    return (m == 0) ? 2'd3 : (m < 3) ? 2'd2 : 2'd1;
  endfunction

  function automatic logic [31:0] exp_rd(logic [1:0] a);
    logic [31:0] r = '0;
    case (a)
      2'd0: begin r[6:0] = m_ctrl; r[9] = dev_intrq; end
      2'd1: r[9:0] = m_cfg;
      2'd2: r[1:0] = {m_rw, m_en};
      default: begin
        r[16] = eng_req; r[17] = m_int; r[18] = eng_busy;
        r[24] = m_ndo; r[25] = m_ndi; r[26] = m_n4x;
      end
    endcase
    return r;
  endfunction

  function automatic logic m_err();
    return m_ndo | m_ndi | m_n4x | m_int;
  endfunction

  task automatic model_reset();
    m_ctrl = 7'h63; m_cfg = 0; m_en = 0; m_rw = 0; m_stage = 0;
    {m_ndo, m_ndi, m_n4x, m_int} = 0;
  endtask

  // One cycle: inputs driven at negedge, combinational checks, then model update.
  task automatic step(bit wr, bit rd, logic [1:0] a, logic [31:0] d, bit stop,
                      logic [3:0] errs, string tag);
    bit clr;
    @(negedge clk);
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d; dma_stop = stop;
    {eng_n4x, eng_ndi, eng_ndo, eng_int} = errs;
    #1;
    if (rd) chk({tag, " R1 R6 R8 read"}, bus_rdata, exp_rd(a));
    chk("R7 R8 R9 summary", {29'b0, sum_err, sum_irq, sum_act},
        {29'b0, m_err(), !m_err() && dev_intrq,
         !m_err() && !dev_intrq && (eng_busy || eng_req)});
    @(posedge clk);
    clr = stop || (wr && a == 2 && d[1:0] == 0);
    if (wr && a == 0) m_ctrl = d[6:0];
    if (stop) m_ctrl = m_ctrl | 7'h63;
    if (wr && a == 1) m_cfg = {d[1] ? hold_of(d[7:4]) : d[9:8], d[7:0]};
    if (stop) begin m_en = 0; m_rw = 0; m_stage = 0; end
    else if (wr && a == 2) begin
      if (!d[0]) begin m_en = 0; m_rw = d[1]; m_stage = 1; end
      else begin
        if (m_stage == 2 && d[1] == m_rw) m_en = 1;
        m_stage = 0;
      end
    end else if (rd && a == 2 && m_stage != 0) m_stage = 2;
    m_ndo = (m_ndo && !clr) || errs[1];
    m_ndi = (m_ndi && !clr) || errs[2];
    m_n4x = (m_n4x && !clr) || errs[3];
    m_int = (m_int && !clr) || errs[0];
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d); step(1, 0, a, d, 0, 0, "wr"); endtask
  task automatic rd(logic [1:0] a, string tag); step(0, 1, a, 0, 0, 0, tag); endtask

  task automatic pins(string tag);
    @(negedge clk); #1;
    chk({tag, " R2 op pins"}, {op_write, op_en}, {m_rw, m_en});
    chk({tag, " R11 ctrl pins"}, {ata_diow_n, ata_dior_n, ata_da, ata_cs1_n, ata_cs0_n}, m_ctrl);
    chk({tag, " R4 cfg pins"}, {cfg_hold, cfg_mode, cfg_udma, cfg_mdma, cfg_pio, cfg_host_en}, m_cfg);
  endtask

  initial begin
    #200000;
    $display("FAIL watchdog expired");
    fails++; checks++;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h1d5e));
    model_reset();
    repeat (3) @(posedge clk);
    rst_n = 1;
    // R1 reset state
    for (int a = 0; a < 4; a++) rd(a[1:0], "R1 reset");
    pins("R1");
    // R3 legal enable, write direction
    wr(2, 2); rd(2, "R3 seq"); wr(2, 3);
    pins("R3 legal write-dir");
    chk("R3 enabled", {31'b0, op_en}, 1);
    // R10 stop
    wr(0, 32'h14);
    step(0, 0, 0, 0, 1, 0, "stop");
    pins("R10 stop");
    chk("R10 address kept", {29'b0, ata_da}, 5);
    // R3 skipped read
    wr(2, 0); wr(2, 1); pins("R3 no read");
    chk("R3 no read", {31'b0, op_en}, 0);
    // R3 direction mismatch
    wr(2, 2); rd(2, "R3"); wr(2, 1); pins("R3 dir mismatch");
    chk("R3 mismatch", {31'b0, op_en}, 0);
    // R3 restart in between
    wr(2, 0); rd(2, "R3"); wr(2, 2); wr(2, 3); pins("R3 restart");
    // R3 other offsets do not disturb, two reads ok
    wr(2, 0); rd(2, "R3"); wr(1, 0); rd(3, "R3"); rd(2, "R3"); wr(2, 1);
    pins("R3 interleaved");
    chk("R3 interleaved enabled", {31'b0, op_en}, 1);
    // R5 hold count per mode, R4 plain
    for (int m = 0; m < 6; m++) begin
      wr(1, {22'b0, 2'b00, m[3:0], 4'b0011});
      rd(1, "R5 hold");
    end
    wr(1, 32'h2f5); rd(1, "R4 raw hold"); pins("R4");
    // R6 R7 sticky errors and clear
    wr(2, 2);
    for (int b = 0; b < 4; b++) begin
      step(0, 0, 0, 0, 0, 4'(1 << b), "err");
      rd(3, "R6 sticky");
      wr(2, 2); rd(3, "R6 still sticky");
      wr(2, 0); rd(3, "R6 cleared");
      wr(2, 2);
    end
    // R6 error arriving during clear is kept
    step(1, 0, 2, 0, 0, 4'b0010, "clr+err");
    rd(3, "R6 err during clear");
    chk("R7 err kept", {31'b0, sum_err}, 1);
    // R8 R9 priority with live inputs
    dev_intrq = 1; eng_busy = 1; rd(0, "R8 intrq under err");
    step(0, 0, 0, 0, 1, 0, "stop clr");
    rd(0, "R8 intrq"); dev_intrq = 0; rd(3, "R9 busy"); eng_busy = 0; eng_req = 1;
    rd(3, "R9 req"); eng_req = 0; rd(3, "R9 idle");
    // R10 stop with simultaneous ctrl write
    step(1, 0, 0, 32'h0c, 1, 0, "stop+wr"); pins("R10 stop priority");
    // random phase
    for (int i = 0; i < 3000; i++) begin
      int k = $urandom_range(0, 19);
      dev_intrq = $urandom_range(0, 3) == 0;
      eng_busy = $urandom_range(0, 2) == 0;
      eng_req = $urandom_range(0, 2) == 0;
      if (k < 5) wr(2, $urandom_range(0, 3));
      else if (k < 10) rd(2, "R3 rand");
      else if (k < 12) wr(1, $urandom);
      else if (k < 14) wr(0, $urandom);
      else if (k < 15) step(0, 0, 0, 0, 1, 0, "R10 rand stop");
      else if (k < 16) step($urandom_range(0, 1), 0, 2, $urandom_range(0, 3), 0,
                            4'(1 << $urandom_range(0, 3)), "R6 rand err");
      else rd($urandom_range(0, 3), "rand");
      if (i % 50 == 0) pins("rand");
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule